// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Event Detection

This block drives and samples a large set of general-purpose pins through a flat 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. The pins are split into equal banks. Each bank sits in its own 128-byte window and has its own copy of every control and status register. Bit k of any bank register belongs to pin k of that bank, and only the low 16 bits of each register carry meaning.

Every pin input passes through a two-stage synchroniser. A per-pin detector then checks the synchronised value for level or edge events. The sensing mode, the polarity and the both-edges choice are set per pin. Latched events can be masked per pin. All enabled events in all banks are merged onto one interrupt line, which is serviced by scanning the masked-status registers and clearing with write-one-to-clear.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: Bank n occupies byte addresses n*0x80 to n*0x80+0x7F. Within a bank the word offsets are: 0x00 data, 0x04 data mask, 0x08 direction, 0x0C sense, 0x10 both-edge, 0x14 polarity, 0x18 interrupt enable, 0x1C raw status, 0x20 masked status, 0x24 clear, 0x28 input enable. A write to one bank leaves the other banks unchanged.
- R2: The control registers (data mask, direction, sense, both-edge, polarity, interrupt enable, input enable) read back their last written low 16 bits, with zeros above. Every register is 0 after reset.
- R3: A direction bit of 1 asserts the pin's output enable and drives the pin from its data bit. A direction bit of 0 releases the pin.
- R4: A write to the data register updates only the bits whose data-mask bit is 1. A data read returns 0 for every bit whose data-mask bit is 0.
- R5: A data read returns the driven value for an output pin. For an input pin it returns the synchronised pin level when the pin's input-enable bit is 1, and 0 when that bit is 0.
- R6: With sense 0 (edge mode), a both-edge bit of 1 latches a raw status bit on rising and falling edges whatever the polarity. With both-edge 0, polarity 1 latches on rising edges only and polarity 0 latches on falling edges only.
- R7: With sense 1 (level mode), the raw status bit follows the enabled input level: polarity 1 means active high, polarity 0 means active low. A clear has no effect while the level is active, and the bit drops once the level goes inactive.
- R8: A pin whose input-enable bit is 0 never sets its raw status bit.
- R9: Writing 1 to a clear bit clears that edge-latched raw status bit, and writing 0 has no effect. If a new edge arrives in the same cycle as the clear, the bit stays set. The clear register reads as 0.
- R10: Masked status equals raw status AND interrupt enable. The interrupt output is high exactly when some masked status bit in some bank is 1.
- R11: Writes to raw status, masked status and unmapped offsets change no readable state. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 11 | Byte address: bank number above the 7-bit in-bank offset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 256 | Raw pin levels, bank-major |
| pin_out | output | 256 | Driven pin values |
| pin_oe | output | 256 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench lines up a clear write with a fresh edge on the same clock edge. A design that lets the clear win would lose that event, and the bench reads the bit back as 0. It also clears a level-mode bit while the level is still active: a design that latches level events would keep the bit after the level goes away, and one that honours the clear would drop it early. Polarity is checked against the wrong-direction edge, and both-edge mode is given a polarity that would reject the edge, to catch decoders that mix up those bits. Other checks look for a data write that leaks through masked bits, an input-disabled pin that still raises status, an event on a pin with its interrupt disabled that still reaches the interrupt line, and a bank window that aliases into its neighbour.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BANK_OFS_W = 7;  // 0x80 bytes per bank window
  typedef logic [BANK_OFS_W-1:0] bank_ofs_t;

  localparam bank_ofs_t OFS_DATA  = 7'h00;
  localparam bank_ofs_t OFS_DMASK = 7'h04;
  localparam bank_ofs_t OFS_DIR   = 7'h08;
  localparam bank_ofs_t OFS_SENSE = 7'h0C;
  localparam bank_ofs_t OFS_BOTH  = 7'h10;
  localparam bank_ofs_t OFS_POL   = 7'h14;
  localparam bank_ofs_t OFS_IE    = 7'h18;
  localparam bank_ofs_t OFS_RAW   = 7'h1C;
  localparam bank_ofs_t OFS_MSK   = 7'h20;
  localparam bank_ofs_t OFS_CLR   = 7'h24;
  localparam bank_ofs_t OFS_INEN  = 7'h28;
endpackage

// File: rtl/gpio_edge_level_detect.sv
module gpio_edge_level_detect #(
  parameter int PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] pin_i,
  input  logic [PW-1:0] inen_i,
  input  logic [PW-1:0] sense_i,
  input  logic [PW-1:0] both_i,
  input  logic [PW-1:0] pol_i,
  input  logic [PW-1:0] clr_i,
  output logic [PW-1:0] sync_o,
  output logic [PW-1:0] raw_o
);
  logic [PW-1:0] meta_q, sync_q, prev_q, raw_q;
  logic [PW-1:0] meta_d, sync_d, prev_d, raw_d;
  logic [PW-1:0] rise, fall, lvl, edge_evt, evt;

  always_comb begin
    meta_d   = pin_i;
    sync_d   = meta_q;
    prev_d   = sync_q;
    rise     = inen_i & sync_q & ~prev_q;
    fall     = inen_i & ~sync_q & prev_q;
    lvl      = inen_i & ~(sync_q ^ pol_i);
    edge_evt = (both_i & (rise | fall)) |
               (~both_i & pol_i & rise) |
               (~both_i & ~pol_i & fall);
    evt      = (sense_i & lvl) | (~sense_i & edge_evt);
    raw_d    = (sense_i & lvl) | (~sense_i & ((raw_q & ~clr_i) | edge_evt));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
      raw_q  <= raw_d;
    end
  end

  assign sync_o = sync_q;
  assign raw_o  = raw_q;

  AST_RAW_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~raw_q)) |=> ((raw_q & ~$past(raw_q) & ~$past(evt)) == '0)); // R6
  AST_NO_EVENT_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~inen_i)) |=> ((raw_q & ~$past(raw_q) & ~$past(inen_i)) == '0)); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~sense_i & ~evt)) |=> ((raw_q & $past(clr_i & ~sense_i & ~evt)) == '0)); // R9
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int PW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  bank_ofs_t     ofs_i,
  input  logic [PW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [PW-1:0] pin_i,
  output logic [PW-1:0] pin_out_o,
  output logic [PW-1:0] pin_oe_o,
  output logic          irq_o
);
  logic [PW-1:0] data_q, dmask_q, dir_q, sense_q, both_q, pol_q, ie_q, inen_q;
  logic [PW-1:0] data_d, dmask_d, dir_d, sense_d, both_d, pol_d, ie_d, inen_d;
  logic [PW-1:0] clr, sync_val, raw, masked, rd_bits;

  always_comb begin
    data_d  = data_q;
    dmask_d = dmask_q;
    dir_d   = dir_q;
    sense_d = sense_q;
    both_d  = both_q;
    pol_d   = pol_q;
    ie_d    = ie_q;
    inen_d  = inen_q;
    clr     = '0;
    if (wr_en_i) begin
      unique case (ofs_i)
        OFS_DATA:  data_d  = (data_q & ~dmask_q) | (wdata_i & dmask_q);
        OFS_DMASK: dmask_d = wdata_i;
        OFS_DIR:   dir_d   = wdata_i;
        OFS_SENSE: sense_d = wdata_i;
        OFS_BOTH:  both_d  = wdata_i;
        OFS_POL:   pol_d   = wdata_i;
        OFS_IE:    ie_d    = wdata_i;
        OFS_CLR:   clr     = wdata_i;
        OFS_INEN:  inen_d  = wdata_i;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      dmask_q <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      ie_q    <= '0;
      inen_q  <= '0;
    end else if (wr_en_i) begin
      data_q  <= data_d;
      dmask_q <= dmask_d;
      dir_q   <= dir_d;
      sense_q <= sense_d;
      both_q  <= both_d;
      pol_q   <= pol_d;
      ie_q    <= ie_d;
      inen_q  <= inen_d;
    end
  end

  gpio_edge_level_detect #(.PW(PW)) det_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .inen_i  (inen_q),
    .sense_i (sense_q),
    .both_i  (both_q),
    .pol_i   (pol_q),
    .clr_i   (clr),
    .sync_o  (sync_val),
    .raw_o   (raw)
  );

  assign masked    = raw & ie_q;
  assign irq_o     = |masked;
  assign pin_out_o = data_q;
  assign pin_oe_o  = dir_q;

  always_comb begin
    unique case (ofs_i)
      OFS_DATA:  rd_bits = dmask_q & ((dir_q & data_q) | (~dir_q & inen_q & sync_val));
      OFS_DMASK: rd_bits = dmask_q;
      OFS_DIR:   rd_bits = dir_q;
      OFS_SENSE: rd_bits = sense_q;
      OFS_BOTH:  rd_bits = both_q;
      OFS_POL:   rd_bits = pol_q;
      OFS_IE:    rd_bits = ie_q;
      OFS_RAW:   rd_bits = raw;
      OFS_MSK:   rd_bits = masked;
      OFS_INEN:  rd_bits = inen_q;
      default:   rd_bits = '0;
    endcase
    rdata_o = '0;
    rdata_o[PW-1:0] = rd_bits;
  end

  AST_DIR_DRIVES_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ofs_i == OFS_DIR) |=> (pin_oe_o == $past(wdata_i))); // R3
  AST_MASKED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ofs_i == OFS_DATA) |=> (((pin_out_o ^ $past(data_q)) & ~$past(dmask_q)) == '0)); // R4
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS     = 16,
  parameter int PINS_PER_BANK = 16,
  parameter int DATA_W        = 32,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = BANK_W + BANK_OFS_W,
  localparam int NUM_PINS = NUM_BANKS * PINS_PER_BANK
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [BANK_W-1:0] bank_sel;
  bank_ofs_t         ofs;
  logic [DATA_W-1:0] bank_rdata [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_irq;
  logic              unused_wdata_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign bank_sel        = bus_addr[ADDR_W-1:BANK_OFS_W];
  assign ofs             = bus_addr[BANK_OFS_W-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:PINS_PER_BANK];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank_regs #(.PW(PINS_PER_BANK), .DW(DATA_W)) bank_i (
      .clk_i     (clk),
      .rst_ni    (rst_n_int),
      .wr_en_i   (bus_we && (bank_sel == BANK_W'(b))),
      .ofs_i     (ofs),
      .wdata_i   (bus_wdata[PINS_PER_BANK-1:0]),
      .rdata_o   (bank_rdata[b]),
      .pin_i     (pin_in[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .pin_out_o (pin_out[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .pin_oe_o  (pin_oe[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .irq_o     (bank_irq[b])
    );
  end

  assign bus_rdata = bank_rdata[bank_sel];
  assign irq       = |bank_irq;

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ofs == OFS_CLR) |-> (bus_rdata == '0)); // R9
  AST_IRQ_OFF_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(rst_n_int) |-> !irq); // R10
endmodule

// File: tb/gpio_banked_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_banked_ctrl_tb_top;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [10:0]   bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [255:0]  pin_in = '0;
  logic [255:0]  pin_out, pin_oe;
  logic          irq;
  int checks = 0;
  int failures = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  gpio_banked_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  localparam int NV = 11;
  localparam logic [10:0] V_ADDR [NV] = '{11'h008, 11'h794, 11'h398, 11'h190, 11'h48C,
                                          11'h0A8, 11'h104, 11'h22C, 11'h29C, 11'h2A0, 11'h2A4};
  localparam logic [31:0] V_WDAT [NV] = '{32'hFFFF_A5A5, 32'h0000_1234, 32'h0000_8001,
                                          32'h0000_00F0, 32'h0000_0F0F, 32'h0000_FFFF,
                                          32'h0000_5555, 32'h0000_FFFF, 32'h0000_FFFF,
                                          32'h0000_FFFF, 32'h0000_FFFF};
  localparam logic [31:0] V_EXP  [NV] = '{32'h0000_A5A5, 32'h0000_1234, 32'h0000_8001,
                                          32'h0000_00F0, 32'h0000_0F0F, 32'h0000_FFFF,
                                          32'h0000_5555, 32'h0, 32'h0, 32'h0, 32'h0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state R2
    rd(11'h008, rv); chk("R2 reset dir", rv, 32'h0);
    rd(11'h7A8, rv); chk("R2 reset inen", rv, 32'h0);
    #1 chk("R2 reset oe", {31'h0, |pin_oe}, 32'h0);
    chk("R10 reset irq", {31'h0, irq}, 32'h0);

    // vector table: R1 R2 R11 R9
    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_WDAT[i]);
      rd(V_ADDR[i], rv);
      chk($sformatf("R2/R11 vector %0d", i), rv, V_EXP[i]);
    end
    rd(11'h088, rv); chk("R1 bank1 dir unaliased", rv, 32'h0);
    rd(11'h008, rv); chk("R1 bank0 dir kept", rv, 32'h0000_A5A5);
    rd(11'h2A4, rv); chk("R9 clear reads zero", rv, 32'h0);

    // output drive R3 R4 R5
    wr(11'h108, 32'h000F);
    wr(11'h100, 32'hFFFF);
    #1 chk("R4 masked data write", {16'h0, pin_out[47:32]}, 32'h5555);
    chk("R3 oe follows dir", {16'h0, pin_oe[47:32]}, 32'h000F);
    chk("R3 bank0 oe", {16'h0, pin_oe[15:0]}, 32'hA5A5);
    rd(11'h100, rv); chk("R5 output readback", rv, 32'h0005);
    wr(11'h104, 32'h00FF);
    wr(11'h100, 32'h0000);
    #1 chk("R4 write keeps masked bits", {16'h0, pin_out[47:32]}, 32'h5500);
    wr(11'h108, 32'h0000);
    #1 chk("R3 dir zero releases", {16'h0, pin_oe[47:32]}, 32'h0);

    // input sampling R5
    wr(11'h084, 32'hFFFF);
    pin_in[31:16] = 16'hBEEF;
    settle();
    rd(11'h080, rv); chk("R5 input readback", rv, 32'hBEEF);
    wr(11'h304, 32'hFFFF);
    pin_in[111:96] = 16'hFFFF;
    settle();
    rd(11'h300, rv); chk("R5 input disabled reads 0", rv, 32'h0);

    // edge detection bank3 R6 R9 R10
    wr(11'h1A8, 32'h0022);
    wr(11'h194, 32'h0002);
    wr(11'h198, 32'h0002);
    @(negedge clk) pin_in[49] = 1'b1;
    settle();
    rd(11'h19C, rv); chk("R6 rising latched", rv, 32'h0002);
    rd(11'h1A0, rv); chk("R10 masked status", rv, 32'h0002);
    chk("R10 irq set", {31'h0, irq}, 32'h1);
    wr(11'h1A4, 32'h0000);
    rd(11'h19C, rv); chk("R9 zero clear no effect", rv, 32'h0002);
    wr(11'h1A4, 32'h0002);
    rd(11'h19C, rv); chk("R9 clear works", rv, 32'h0);
    chk("R10 irq drops", {31'h0, irq}, 32'h0);
    @(negedge clk) pin_in[49] = 1'b0;
    settle();
    rd(11'h19C, rv); chk("R6 falling ignored with pol 1", rv, 32'h0);
    wr(11'h194, 32'h0000);
    @(negedge clk) pin_in[49] = 1'b1;
    settle();
    rd(11'h19C, rv); chk("R6 rising ignored with pol 0", rv, 32'h0);
    @(negedge clk) pin_in[49] = 1'b0;
    settle();
    rd(11'h19C, rv); chk("R6 falling latched pol 0", rv, 32'h0002);
    wr(11'h1A4, 32'h0002);

    // both edges on pin5, polarity 0, interrupt disabled
    @(negedge clk) pin_in[53] = 1'b1;
    settle();
    rd(11'h19C, rv); chk("R6 both-edge rising", rv, 32'h0020);
    rd(11'h1A0, rv); chk("R10 masked off", rv, 32'h0);
    chk("R10 irq stays low", {31'h0, irq}, 32'h0);
    wr(11'h1A4, 32'h0020);
    @(negedge clk) pin_in[53] = 1'b0;
    settle();
    rd(11'h19C, rv); chk("R6 both-edge falling", rv, 32'h0020);
    // new edge arrives on the same clock edge as a clear
    @(negedge clk) pin_in[53] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 11'h1A4; bus_wdata = 32'h0020; bus_we = 1'b1;
    @(negedge clk) bus_we = 1'b0;
    settle();
    rd(11'h19C, rv); chk("R9 edge wins over clear", rv, 32'h0020);
    wr(11'h1A4, 32'h0020);
    rd(11'h19C, rv); chk("R9 later clear", rv, 32'h0);

    // input enable off R8
    @(negedge clk) pin_in[50] = 1'b1;
    settle();
    rd(11'h19C, rv); chk("R8 no event when input off", rv, 32'h0);

    // level detection bank9 R7
    wr(11'h494, 32'h0001);
    wr(11'h4A8, 32'h0003);
    settle();
    rd(11'h49C, rv); chk("R7 active low level", rv, 32'h0002);
    @(negedge clk) pin_in[144] = 1'b1;
    settle();
    rd(11'h49C, rv); chk("R7 active high level", rv, 32'h0003);
    wr(11'h4A4, 32'h0003);
    rd(11'h49C, rv); chk("R7 clear ignored while active", rv, 32'h0003);
    @(negedge clk) begin pin_in[144] = 1'b0; pin_in[145] = 1'b1; end
    settle();
    rd(11'h49C, rv); chk("R7 level released", rv, 32'h0);

    // combined interrupt from the last bank R10
    wr(11'h7A8, 32'h1000);
    wr(11'h798, 32'h1000);
    @(negedge clk) pin_in[252] = 1'b1;
    settle();
    chk("R10 irq from bank 15", {31'h0, irq}, 32'h1);
    wr(11'h7A4, 32'h1000);
    #1 chk("R10 irq cleared", {31'h0, irq}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule